// File: doc/BRIEF.md
# Load-Use Stall and Taken-Branch Flush Controller

This block is the hazard controller of a five-stage in-order pipeline. Each cycle it compares the destination register of the instruction sitting in execute against both source registers of the instruction sitting in decode. When the execute-stage instruction is a load and either source matches, the decode instruction cannot yet receive the loaded value. The controller then holds the program counter and the fetch/decode register for one cycle and selects all-zero control fields for the decode/execute register. The result is a single bubble that writes neither registers nor memory. After that bubble the load has moved one stage on, and the forwarding path (outside this block) supplies the value.

Branches resolve in decode and fetch continues sequentially, as if every branch were not taken. When decode reports a taken branch, the controller flushes the instruction that was fetched behind it: the fetch/decode register loads the all-zero nop encoding. This costs one cycle. If a load-use stall and a taken branch arrive in the same cycle, the stall wins. The branch stays in decode and is evaluated again on the next cycle, when its operands are valid.

The outputs are combinational, so they act in the same cycle as the condition they answer. During the synchronous active-high reset, the controller requests both the nop load of the fetch/decode register and the zero-control select, so that the pipeline registers clear to the nop state.

Top module: `hazard_ctl`

## Requirements
- R1: Outside reset, when `ex_is_load`=1 and `ex_dst` equals `dec_src_a`, `bubble_sel` is 1.
- R2: Outside reset, when `ex_is_load`=1 and `ex_dst` equals `dec_src_b`, `bubble_sel` is 1.
- R3: Outside reset, `bubble_sel` is 0 whenever `ex_is_load`=0 or `ex_dst` matches neither source register. In that case `pc_we`=1 and `fetch_reg_we`=1.
- R4: Whenever a load-use stall is active, `pc_we`=0 and `fetch_reg_we`=0, so the program counter and the decode instruction are held.
- R5: A stall lasts for the single cycle in which the match is present, and `bubble_sel`=1 in exactly that cycle.
- R6: Outside reset, with no stall and `dec_br_taken`=1, `fetch_flush`=1, `pc_we`=1 and `fetch_reg_we`=1.
- R7: When a stall and `dec_br_taken`=1 coincide, the stall takes priority: `fetch_flush`=0, `pc_we`=0, `fetch_reg_we`=0 and `bubble_sel`=1.
- R8: While `rst`=1, every input is ignored and the outputs are `pc_we`=0, `fetch_reg_we`=0, `bubble_sel`=1 and `fetch_flush`=1.
- R9: Outside reset, with no stall and `dec_br_taken`=0, the outputs are `pc_we`=1, `fetch_reg_we`=1, `bubble_sel`=0 and `fetch_flush`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset of the pipeline registers being controlled |
| ex_is_load | input | 1 | The execute-stage instruction reads data memory (it is a load) |
| ex_dst | input | RW | Destination register number of the execute-stage instruction |
| dec_src_a | input | RW | First source register number of the decode-stage instruction |
| dec_src_b | input | RW | Second source register number of the decode-stage instruction |
| dec_br_taken | input | 1 | Decode resolved a branch as taken this cycle |
| pc_we | output | 1 | Program counter write enable |
| fetch_reg_we | output | 1 | Fetch/decode pipeline register write enable |
| bubble_sel | output | 1 | Select all-zero control fields into the decode/execute register |
| fetch_flush | output | 1 | Load the all-zero nop encoding into the fetch/decode register |

## Verification
The two functions that can fall in the same cycle are the load-use stall and the taken-branch flush. The bench provokes this overlap by sweeping every combination of load flag, destination, both sources and branch flag over a small register-number width. Every combination in which a source matches a load destination while the branch flag is set is therefore applied. In each such case the bench checks that the hold and the zero-control select appear, that the flush is absent, and that when the stall condition is removed, the same branch produces a flush with both enables raised.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef struct packed {
    logic pc_we;
    logic fetch_we;
    logic bubble;
    logic flush;
  } hz_ctl_t;

  localparam int NUM_SRC = 2;

endpackage

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int RW = 5,
  parameter int NS = 2
) (
  input  logic               ex_is_load,
  input  logic [RW-1:0]      ex_dst,
  input  logic [NS*RW-1:0]   src_flat,
  output logic               need_stall
);

  logic [NS-1:0] hit;

  for (genvar g = 0; g < NS; g++) begin : g_cmp
    assign hit[g] = (src_flat[g*RW +: RW] == ex_dst);
  end

  assign need_stall = ex_is_load & (|hit);

endmodule

// File: rtl/hz_branch_flush.sv
module hz_branch_flush (
  input  logic br_taken,
  input  logic stall,
  output logic flush_req
);

  // a stalled branch is re-evaluated next cycle, so it may not flush now
  assign flush_req = br_taken & ~stall;

endmodule

// File: rtl/hz_arbiter.sv
module hz_arbiter
  import hazard_pkg::*;
(
  input  logic    rst,
  input  logic    stall,
  input  logic    flush_req,
  output hz_ctl_t ctl
);

  always_comb begin
    ctl = '{pc_we: 1'b1, fetch_we: 1'b1, bubble: 1'b0, flush: 1'b0};
    if (rst) begin
      ctl = '{pc_we: 1'b0, fetch_we: 1'b0, bubble: 1'b1, flush: 1'b1};
    end else if (stall) begin
      ctl.pc_we    = 1'b0;
      ctl.fetch_we = 1'b0;
      ctl.bubble   = 1'b1;
    end else if (flush_req) begin
      ctl.flush    = 1'b1;
    end
  end

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hazard_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          rst,
  input  logic          ex_is_load,
  input  logic [RW-1:0] ex_dst,
  input  logic [RW-1:0] dec_src_a,
  input  logic [RW-1:0] dec_src_b,
  input  logic          dec_br_taken,
  output logic          pc_we,
  output logic          fetch_reg_we,
  output logic          bubble_sel,
  output logic          fetch_flush
);

  localparam int SRCW = NUM_SRC * RW;

  logic [SRCW-1:0] srcs;
  logic            stall;
  logic            flush_req;
  hz_ctl_t         ctl;

  assign srcs = {dec_src_b, dec_src_a};

  hz_load_use #(.RW(RW), .NS(NUM_SRC)) u_lu (
    .ex_is_load (ex_is_load),
    .ex_dst     (ex_dst),
    .src_flat   (srcs),
    .need_stall (stall)
  );

  hz_branch_flush u_bf (
    .br_taken  (dec_br_taken),
    .stall     (stall),
    .flush_req (flush_req)
  );

  hz_arbiter u_arb (
    .rst       (rst),
    .stall     (stall),
    .flush_req (flush_req),
    .ctl       (ctl)
  );

  assign pc_we        = ctl.pc_we;
  assign fetch_reg_we = ctl.fetch_we;
  assign bubble_sel   = ctl.bubble;
  assign fetch_flush  = ctl.flush;

endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int RW = 5
) (
  input logic          rst,
  input logic          ex_is_load,
  input logic [RW-1:0] ex_dst,
  input logic [RW-1:0] dec_src_a,
  input logic [RW-1:0] dec_src_b,
  input logic          dec_br_taken,
  input logic          pc_we,
  input logic          fetch_reg_we,
  input logic          bubble_sel,
  input logic          fetch_flush
);

  always_comb begin
    if (!rst) begin
      assert_match_a_R1: assert (!(ex_is_load && ex_dst == dec_src_a) || bubble_sel)
        else $error("R1: load match on source a without bubble");
      assert_match_b_R2: assert (!(ex_is_load && ex_dst == dec_src_b) || bubble_sel)
        else $error("R2: load match on source b without bubble");
      assert_no_load_R3: assert (ex_is_load || !bubble_sel)
        else $error("R3: bubble without a load in execute");
      assert_freeze_R4: assert (!bubble_sel || (!pc_we && !fetch_reg_we))
        else $error("R4: bubble while front end advances");
      assert_flush_R6: assert (!(dec_br_taken && !bubble_sel) || fetch_flush)
        else $error("R6: taken branch not flushed");
      assert_priority_R7: assert (!(bubble_sel && fetch_flush))
        else $error("R7: stall and flush together");
    end else begin
      assert_reset_R8: assert (bubble_sel && fetch_flush && !pc_we && !fetch_reg_we)
        else $error("R8: outputs not in reset state");
    end
  end

endmodule

bind hazard_ctl hazard_ctl_chk #(.RW(RW)) u_chk (
  .rst          (rst),
  .ex_is_load   (ex_is_load),
  .ex_dst       (ex_dst),
  .dec_src_a    (dec_src_a),
  .dec_src_b    (dec_src_b),
  .dec_br_taken (dec_br_taken),
  .pc_we        (pc_we),
  .fetch_reg_we (fetch_reg_we),
  .bubble_sel   (bubble_sel),
  .fetch_flush  (fetch_flush)
);

// File: tb/hazard_ctl_test.sv
module hazard_ctl_test;

  localparam int CLK_PERIOD = 10;
  localparam int RW         = 2;
  localparam int NR         = 1 << RW;
  localparam int WATCHDOG   = 20000;

  logic          clk = 1'b0;
  logic          rst;
  logic          ex_is_load;
  logic [RW-1:0] ex_dst;
  logic [RW-1:0] dec_src_a;
  logic [RW-1:0] dec_src_b;
  logic          dec_br_taken;
  logic          pc_we;
  logic          fetch_reg_we;
  logic          bubble_sel;
  logic          fetch_flush;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_ctl #(.RW(RW)) uut (
    .rst          (rst),
    .ex_is_load   (ex_is_load),
    .ex_dst       (ex_dst),
    .dec_src_a    (dec_src_a),
    .dec_src_b    (dec_src_b),
    .dec_br_taken (dec_br_taken),
    .pc_we        (pc_we),
    .fetch_reg_we (fetch_reg_we),
    .bubble_sel   (bubble_sel),
    .fetch_flush  (fetch_flush)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0b expected %0b (load=%0b dst=%0d a=%0d b=%0d br=%0b rst=%0b)",
               tag, what, act, exp, ex_is_load, ex_dst, dec_src_a, dec_src_b, dec_br_taken, rst);
    end
  endtask

  task automatic apply(input logic r, input logic ld, input int d, input int a, input int b, input logic br);
    @(negedge clk);
    rst = r; ex_is_load = ld; ex_dst = RW'(d); dec_src_a = RW'(a); dec_src_b = RW'(b); dec_br_taken = br;
    #1;
  endtask

  initial begin
    rst = 1'b1; ex_is_load = 1'b0; ex_dst = '0; dec_src_a = '0; dec_src_b = '0; dec_br_taken = 1'b0;

    // R8: reset overrides every input pattern
    for (int p = 0; p < 4; p++) begin
      apply(1'b1, p[0], p, 3 - p, p, p[1]);
      check("R8", "pc_we", pc_we, 1'b0);
      check("R8", "fetch_reg_we", fetch_reg_we, 1'b0);
      check("R8", "bubble_sel", bubble_sel, 1'b1);
      check("R8", "fetch_flush", fetch_flush, 1'b1);
    end

    // Exhaustive sweep outside reset
    for (int ld = 0; ld < 2; ld++)
      for (int br = 0; br < 2; br++)
        for (int d = 0; d < NR; d++)
          for (int a = 0; a < NR; a++)
            for (int b = 0; b < NR; b++) begin
              bit ma, mb, st;
              string tb_, tf, tp;
              apply(1'b0, ld[0], d, a, b, br[0]);
              ma = (ld == 1) && (a == d);
              mb = (ld == 1) && (b == d);
              st = ma || mb;
              tb_ = st ? (ma ? "R1/R5" : "R2/R5") : "R3/R5";
              tp  = st ? "R4" : (br == 1 ? "R6" : "R3/R9");
              tf  = (st && br == 1) ? "R7" : (br == 1 ? "R6" : "R9");
              check(tb_, "bubble_sel", bubble_sel, st);
              check(tp, "pc_we", pc_we, !st);
              check(tp, "fetch_reg_we", fetch_reg_we, !st);
              check(tf, "fetch_flush", fetch_flush, (br == 1) && !st);
            end

    // R7 then R6: stalled branch re-evaluated next cycle once load has moved on
    apply(1'b0, 1'b1, 2, 2, 0, 1'b1);
    check("R7", "fetch_flush held", fetch_flush, 1'b0);
    check("R7", "pc_we held", pc_we, 1'b0);
    apply(1'b0, 1'b0, 0, 2, 0, 1'b1);
    check("R6", "fetch_flush retry", fetch_flush, 1'b1);
    check("R5", "bubble ends", bubble_sel, 1'b0);

    // R8 again: reset re-entered after activity
    apply(1'b1, 1'b0, 0, 1, 2, 1'b0);
    check("R8", "bubble_sel re-reset", bubble_sel, 1'b1);
    check("R8", "pc_we re-reset", pc_we, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

endmodule